// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Edge-Triggered Interrupt

The controller manages 128 general-purpose pins arranged as four banks of 32. Software reaches it through a simple single-cycle register port: a write strobe with address and data, and a read strobe whose data comes back one clock later. Each bank holds the pin direction, the output value, two edge-detect enables (rising and falling), a sticky edge status, and an interrupt enable mask. Direction, output value and both edge enables can be changed bit by bit through write-only set and clear aliases. Software can therefore touch one pin without a read-modify-write.

Pin inputs are brought into the clock domain by a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one cycle earlier. An enabled edge latches the pin's status bit, and software clears that bit by writing a one to it. A single interrupt line is raised while any bank has a status bit set whose mask bit is also set. Status is recorded for masked pins too, so software can poll it.

The four banks sit at base offsets 0x000, 0x004, 0x008 and 0x100. Registers inside a bank are spaced 12 bytes apart, so the first three banks interleave word by word.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register is zero. This means pins_out and pins_oe are all zero, irq is low, and every readable register reads zero.
- R2: A register's byte address is its bank base plus 12 times its index. The bank bases are 0x000, 0x004, 0x008 and 0x100 for banks 0 to 3. The indices are: 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 edge status, 7 direction set, 8 direction clear, 9 rising set, 10 rising clear, 11 falling set, 12 falling clear, 13 interrupt mask. Pin p of bank b is bit 32*b+p of the pin vectors and bit p of the bank's registers.
- R3: The level register reads the synchronised pin inputs. An input change is readable once two clock edges have passed. Writes to the level register are ignored.
- R4: A write to the direction register replaces its value, and the value reads back. pins_oe for a pin equals its direction bit, where 1 means output.
- R5: A 1 written to the direction set (or clear) alias sets (or clears) the matching direction bit. A 0 leaves that bit unchanged. Both aliases read as zero.
- R6: A 1 written to the output set (or clear) register sets (or clears) the matching pins_out bit. A 0 leaves that bit unchanged. Both registers read as zero.
- R7: A direct write to the rising or falling enable replaces the whole value. The matching set and clear aliases change only the bits written as 1.
- R8: A 0-to-1 change of the synchronised input sets the pin's status bit when its rising enable is 1. A 1-to-0 change sets it when its falling enable is 1. An edge whose enable is 0 sets nothing. The status bit is readable three clock edges after the input changes.
- R9: Writing 1 to an edge status bit clears it. Writing 0 leaves it unchanged.
- R10: If an enabled edge arrives on the same clock edge as a clear of the same status bit, the bit stays set.
- R11: irq is high exactly when some bank has a status bit set together with the same mask bit. Status is still recorded while the mask bit is 0.
- R12: Read data appears on rdata one clock after rd_en and holds until the next read. Addresses that decode to no register read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pins_in | input | 128 | Raw pin inputs |
| pins_out | output | 128 | Pin output values |
| pins_oe | output | 128 | Pin output enables (1 = drive) |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest situation to produce from the ports is a status clear and a fresh edge on the same pin landing on the same clock edge. The edge reaches the status logic only after the synchroniser and the previous-value flop. The stimulus first sets the status bit with one edge and returns the pin low. It then raises the pin again just after a falling clock edge, lets two rising clock edges pass, and asserts the write-one-to-clear strobe so that the write lands on the third edge. A read afterwards must still show the bit set. The interleaved bank map is exercised by writes to banks 1, 2 and 3 while bank 0's outputs are watched for disturbance.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int NBANK      = 4;
    localparam int PINS       = 32;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 10;
    localparam int NREG       = 14;
    localparam int REG_STRIDE = 12;
    localparam int BANK_W     = $clog2(NBANK);
    localparam int IDX_W      = 4;
    localparam int ALL_PINS   = NBANK * PINS;

    typedef enum logic [IDX_W-1:0] {
        RG_LEVEL    = 4'd0,
        RG_DIR      = 4'd1,
        RG_OUT_SET  = 4'd2,
        RG_OUT_CLR  = 4'd3,
        RG_RISE     = 4'd4,
        RG_FALL     = 4'd5,
        RG_STAT     = 4'd6,
        RG_DIR_SET  = 4'd7,
        RG_DIR_CLR  = 4'd8,
        RG_RISE_SET = 4'd9,
        RG_RISE_CLR = 4'd10,
        RG_FALL_SET = 4'd11,
        RG_FALL_CLR = 4'd12,
        RG_MASK     = 4'd13,
        RG_NONE     = 4'd15
    } reg_sel_e;

    // Base byte offset of each bank; three banks interleave, the fourth is apart.
    function automatic int bank_base(input int b);
        case (b)
            0:       return 'h000;
            1:       return 'h004;
            2:       return 'h008;
            default: return 'h100;
        endcase
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_edge_decode.sv
module gpio_edge_decode
    import gpio_edge_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BANK_W-1:0] bank,
    output reg_sel_e          sel
);

    always_comb begin
        int rel;
        hit  = 1'b0;
        bank = '0;
        sel  = RG_NONE;
        rel  = 0;
        for (int b = 0; b < NBANK; b++) begin
            rel = int'(addr) - bank_base(b);
            if (rel >= 0 && (rel % REG_STRIDE) == 0 && (rel / REG_STRIDE) < NREG) begin
                hit  = 1'b1;
                bank = BANK_W'(b);
                sel  = reg_sel_e'(IDX_W'(rel / REG_STRIDE));
            end
        end
    end

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int W = PINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_now,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] rd_word,
    output logic         irq_b
);

    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] hit_rise;
    logic [W-1:0] hit_fall;
    logic [W-1:0] clr_bits;

    assign hit_rise = rise_q & pin_now & ~prev_q;
    assign hit_fall = fall_q & ~pin_now & prev_q;
    assign clr_bits = (wr && sel == RG_STAT) ? wdata : '0;

    // Status: new edges are ORed in after the clear, so an edge wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= pin_now;
            stat_q <= (stat_q & ~clr_bits) | hit_rise | hit_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            mask_q <= '0;
        end else if (wr) begin
            unique case (sel)
                RG_DIR:      dir_q  <= wdata;
                RG_DIR_SET:  dir_q  <= dir_q | wdata;
                RG_DIR_CLR:  dir_q  <= dir_q & ~wdata;
                RG_OUT_SET:  out_q  <= out_q | wdata;
                RG_OUT_CLR:  out_q  <= out_q & ~wdata;
                RG_RISE:     rise_q <= wdata;
                RG_RISE_SET: rise_q <= rise_q | wdata;
                RG_RISE_CLR: rise_q <= rise_q & ~wdata;
                RG_FALL:     fall_q <= wdata;
                RG_FALL_SET: fall_q <= fall_q | wdata;
                RG_FALL_CLR: fall_q <= fall_q & ~wdata;
                RG_MASK:     mask_q <= wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            RG_LEVEL: rd_word = pin_now;
            RG_DIR:   rd_word = dir_q;
            RG_RISE:  rd_word = rise_q;
            RG_FALL:  rd_word = fall_q;
            RG_STAT:  rd_word = stat_q;
            RG_MASK:  rd_word = mask_q;
            default:  rd_word = '0;
        endcase
    end

    assign irq_b = |(stat_q & mask_q);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [ALL_PINS-1:0] pins_in,
    output logic [ALL_PINS-1:0] pins_out,
    output logic [ALL_PINS-1:0] pins_oe,
    output logic                irq
);

    logic [ALL_PINS-1:0] pin_sync;
    logic                dec_hit;
    logic [BANK_W-1:0]   dec_bank;
    reg_sel_e            dec_sel;
    logic [PINS-1:0]     rd_words [NBANK];
    logic [NBANK-1:0]    irq_bits;

    gpio_edge_sync #(.W(ALL_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pins_in),
        .sync_out (pin_sync)
    );

    gpio_edge_decode u_decode (
        .addr (addr),
        .hit  (dec_hit),
        .bank (dec_bank),
        .sel  (dec_sel)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en && dec_hit && (dec_bank == BANK_W'(g));

        gpio_edge_bank #(.W(PINS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (bank_wr),
            .sel     (dec_sel),
            .wdata   (wdata[PINS-1:0]),
            .pin_now (pin_sync[g*PINS +: PINS]),
            .dir_q   (pins_oe[g*PINS +: PINS]),
            .out_q   (pins_out[g*PINS +: PINS]),
            .rd_word (rd_words[g]),
            .irq_b   (irq_bits[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= dec_hit ? rd_words[dec_bank] : '0;
        end
    end

    assign irq = |irq_bits;

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
    import gpio_edge_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata,
    input logic [ALL_PINS-1:0] pins_out,
    input logic [ALL_PINS-1:0] pins_oe
);

    localparam logic [ADDR_W-1:0] A_OUT_SET0 = ADDR_W'(REG_STRIDE * 2);
    localparam logic [ADDR_W-1:0] A_DIR_SET0 = ADDR_W'(REG_STRIDE * 7);
    localparam logic [ADDR_W-1:0] A_DIR_CLR0 = ADDR_W'(REG_STRIDE * 8);

    // R5
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR_SET0) |=> ((pins_oe[PINS-1:0] & $past(wdata)) == $past(wdata)));

    // R5
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR_CLR0) |=> ((pins_oe[PINS-1:0] & $past(wdata)) == '0));

    // R6
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_OUT_SET0) |=> ((pins_out[PINS-1:0] & $past(wdata)) == $past(wdata)));

    // R6
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_OUT_SET0) |=> (rdata == '0));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind gpio_edge_ctrl gpio_edge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pins_out (pins_out),
    .pins_oe  (pins_oe)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [9:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] pins_in = '0;
    logic [127:0] pins_out;
    logic [127:0] pins_oe;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .pins_in  (pins_in),
        .pins_out (pins_out),
        .pins_oe  (pins_oe),
        .irq      (irq)
    );

    always #5 clk = ~clk;

    function automatic logic [9:0] ra(input int b, input int idx);
        int base;
        base = (b == 0) ? 'h000 : (b == 1) ? 'h004 : (b == 2) ? 'h008 : 'h100;
        return 10'(base + 12 * idx);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pins_oe", pins_oe[31:0] | pins_oe[127:96], 32'h0);
        chk("R1 pins_out", pins_out[31:0] | pins_out[127:96], 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(ra(0, 1), v);  chk("R1 dir", v, 32'h0);
        rd(ra(3, 13), v); chk("R1 mask", v, 32'h0);
    endtask

    task automatic t_direction();
        logic [31:0] v;
        wr(ra(1, 1), 32'hA5A5_0F0F);
        rd(ra(1, 1), v);
        chk("R4 dir readback", v, 32'hA5A5_0F0F);
        chk("R4 pins_oe bank1", pins_oe[63:32], 32'hA5A5_0F0F);
        chk("R2 bank0 untouched", pins_oe[31:0], 32'h0);
        wr(ra(2, 7), 32'h0000_00F0);
        wr(ra(2, 8), 32'h0000_0030);
        chk("R5 set/clear aliases", pins_oe[95:64], 32'h0000_00C0);
        rd(ra(2, 7), v);
        chk("R5 alias reads zero", v, 32'h0);
    endtask

    task automatic t_output();
        logic [31:0] v;
        wr(ra(3, 2), 32'hFF00_0000);
        wr(ra(3, 3), 32'h0F00_0000);
        chk("R6 pins_out bank3", pins_out[127:96], 32'hF000_0000);
        chk("R2 bank2 out untouched", pins_out[95:64], 32'h0);
        rd(ra(3, 3), v);
        chk("R6 clear reads zero", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk);
        pins_in[31:0] = 32'h1234_5678;
        settle();
        rd(ra(0, 0), v);
        chk("R3 level", v, 32'h1234_5678);
        wr(ra(0, 0), 32'hFFFF_FFFF);
        rd(ra(0, 0), v);
        chk("R3 level write ignored", v, 32'h1234_5678);
    endtask

    task automatic t_enables();
        logic [31:0] v;
        wr(ra(0, 4), 32'hFFFF_0000);
        rd(ra(0, 4), v); chk("R7 rise direct", v, 32'hFFFF_0000);
        wr(ra(0, 9), 32'h0000_0001);
        wr(ra(0, 10), 32'hFFFF_0000);
        rd(ra(0, 4), v); chk("R7 rise aliases", v, 32'h0000_0001);
        wr(ra(0, 11), 32'h0000_0002);
        rd(ra(0, 5), v); chk("R7 fall set", v, 32'h0000_0002);
        wr(ra(0, 5), 32'h0000_0004);
        rd(ra(0, 5), v); chk("R7 fall direct", v, 32'h0000_0004);
        wr(ra(0, 12), 32'h0000_0000);
        rd(ra(0, 5), v); chk("R7 clear zero no effect", v, 32'h0000_0004);
    endtask

    task automatic t_edges();
        logic [31:0] v;
        // bank0: rise enable bit0, fall enable bit2; pins bits 0..2 are 0
        @(negedge clk); pins_in[0] = 1'b1; settle();
        @(negedge clk); pins_in[1] = 1'b1; settle();
        @(negedge clk); pins_in[2] = 1'b1; settle();
        rd(ra(0, 6), v);
        chk("R8 rise only where enabled", v, 32'h0000_0001);
        @(negedge clk); pins_in[2] = 1'b0; pins_in[0] = 1'b0; settle();
        rd(ra(0, 6), v);
        chk("R8 fall enabled, bit0 fall ignored", v, 32'h0000_0005);
        wr(ra(0, 6), 32'h0000_0004);
        rd(ra(0, 6), v); chk("R9 clear one bit", v, 32'h0000_0001);
        wr(ra(0, 6), 32'h0000_0000);
        rd(ra(0, 6), v); chk("R9 write zero no effect", v, 32'h0000_0001);
        wr(ra(0, 6), 32'h0000_0001);
        rd(ra(0, 6), v); chk("R9 cleared", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); pins_in[0] = 1'b1; settle();
        chk("R11 masked irq low", {31'b0, irq}, 32'h0);
        rd(ra(0, 6), v); chk("R11 masked status recorded", v, 32'h1);
        wr(ra(0, 13), 32'h0000_0001);
        chk("R11 irq high after unmask", {31'b0, irq}, 32'h1);
        wr(ra(0, 6), 32'h0000_0001);
        chk("R11 irq low after clear", {31'b0, irq}, 32'h0);
        wr(ra(3, 4), 32'h8000_0000);
        wr(ra(3, 13), 32'h8000_0000);
        @(negedge clk); pins_in[127] = 1'b1; settle();
        chk("R11 irq from bank3", {31'b0, irq}, 32'h1);
        wr(ra(3, 6), 32'h8000_0000);
        chk("R11 bank3 cleared", {31'b0, irq}, 32'h0);
        @(negedge clk); pins_in[0] = 1'b0; settle();
    endtask

    task automatic t_collision();
        logic [31:0] v;
        @(negedge clk); pins_in[0] = 1'b1; settle();
        @(negedge clk); pins_in[0] = 1'b0; settle();
        rd(ra(0, 6), v); chk("R10 setup status", v, 32'h1);
        @(negedge clk); pins_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = ra(0, 6); wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(ra(0, 6), v); chk("R10 edge wins over clear", v, 32'h1);
        wr(ra(0, 6), 32'h1);
        rd(ra(0, 6), v); chk("R10 later clear works", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        logic [31:0] held;
        wr(10'h0FC, 32'hFFFF_FFFF);
        wr(10'h002, 32'hFFFF_FFFF);
        chk("R12 unmapped write no effect", pins_oe[31:0], 32'h0);
        rd(10'h0FC, v); chk("R12 unmapped reads zero", v, 32'h0);
        rd(ra(1, 1), held);
        repeat (4) @(negedge clk);
        chk("R12 rdata holds", rdata, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_output();
        t_level();
        t_enables();
        t_edges();
        t_irq();
        t_collision();
        t_unmapped();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule